// File: doc/BRIEF.md
# Multi-Port Burst Frame Receiver

This block sits behind a set of parallel receive lanes. Every lane presents a 33-bit word each clock: a 32-bit payload plus a flag, in the top bit, that marks the payload as new. A periodic step strobe divides time into calculation steps. Each lane runs in one of two modes. In the single-sample mode it takes the first flagged word of a step and ignores the rest. In the burst mode it takes up to a fixed limit of words per step. Words past that limit are dropped, and a sticky overrun flag records the loss.

For each lane the block can raise a one-clock start-of-frame pulse that marks the first accepted word of a step. Downstream logic uses it to split a burst back into frames. The pulse either leads that word by one clock or lines up with it. An optional protection gate follows the application run state. When the gate is closed, no word is taken and the lane's data output loads a programmable default.

Top module: `frame_rx`

## Requirements
- R1: A lane word carries its payload in bits 31:0 and its valid flag in bit 32. An accepted word shows on `out_data`/`out_valid` exactly two clocks after it is presented, with `out_valid` high for one clock.
- R2: Bit i of `async_mask` places lane i (bit 0 is lane 0) in burst mode when 1 and in single-sample mode when 0.
- R3: In single-sample mode only the first flagged, permitted word of a step is accepted. Later flagged words in the same step produce no `out_valid`.
- R4: In burst mode up to MAX_BURST (default 254) permitted words per step are accepted and the rest are dropped. A word presented in the same cycle as `step_strobe` counts as the first word of the new step.
- R5: `overflow[i]` goes high one clock after a permitted flagged word is dropped on a burst lane for lack of room. It then stays high until reset, and it never rises on a single-sample lane.
- R6: `out_sof[i]` pulses for one clock only when bit i of `sof_en_mask` is set, and only for the first accepted word of a step.
- R7: With `sof_align` = 1 the start-of-frame pulse falls in the same cycle as the `out_valid` of that first word.
- R8: With `sof_align` = 0 the start-of-frame pulse falls one cycle before the `out_valid` of that first word.
- R9: With `protect_en` = 1, words pass only while `app_state` is Execute (1), or Pause (2) when the last state other than Pause was Execute. Stop (0) and the unused code 3 block all words.
- R10: When protection blocks a cycle, two clocks later every lane's `out_data` equals `default_data` and `out_valid` is low.
- R11: With `protect_en` = 0 words pass whatever `app_state` holds.
- R12: While `rst_n` is low all outputs are zero and the run-state history is Stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_word | input | NPORTS*33 | Lane words, lane i at bits 33*i+32 : 33*i |
| step_strobe | input | 1 | Marks the first cycle of a calculation step |
| app_state | input | 2 | Run state: 0 Stop, 1 Execute, 2 Pause |
| protect_en | input | 1 | Enables the run-state gate |
| async_mask | input | NPORTS | Per-lane burst-mode select |
| sof_en_mask | input | NPORTS | Per-lane start-of-frame enable |
| sof_align | input | 1 | 1: pulse aligned with first word, 0: one cycle ahead |
| default_data | input | 32 | Payload loaded while protection blocks |
| out_data | output | NPORTS*32 | Lane payload outputs |
| out_valid | output | NPORTS | Lane valid outputs |
| out_sof | output | NPORTS | Lane start-of-frame pulses |
| overflow | output | NPORTS | Sticky per-lane burst overrun flags |

## Verification
A step strobe and a flagged word can land in the same cycle. The word must then open the new step: it is accepted, it restarts the count and it carries the start-of-frame pulse. The bench drives strobes on a fixed period under pseudo-random valid patterns, so this coincidence happens often on both single-sample and burst lanes. A cycle-level model in the bench judges every output in every cycle. The overrun case and the Stop/Execute/Pause transitions under protection are swept in the same way, and explicit counts of accepted burst words are checked at the burst limit.

// File: rtl/frame_rx_pkg.sv
package frame_rx_pkg;

  typedef enum logic [1:0] {
    RS_STOP  = 2'd0,
    RS_EXEC  = 2'd1,
    RS_PAUSE = 2'd2,
    RS_RSVD  = 2'd3
  } run_state_e;

  // Gate decision: open in Execute, or in Pause when Execute came before.
  function automatic logic gate_open(input logic protect,
                                     input logic [1:0] cur,
                                     input logic [1:0] prior);
    if (!protect) return 1'b1;
    if (cur == RS_EXEC) return 1'b1;
    if (cur == RS_PAUSE && prior == RS_EXEC) return 1'b1;
    return 1'b0;
  endfunction

endpackage

// File: rtl/frame_rx_gate.sv
module frame_rx_gate
  import frame_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       protect_en,
  input  logic [1:0] app_state,
  output logic       pass,
  output logic       blocked
);

  logic [1:0] prior_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prior_q <= RS_STOP;
    end else if (app_state != RS_PAUSE) begin
      prior_q <= app_state;
    end
  end

  assign pass    = gate_open(protect_en, app_state, prior_q);
  assign blocked = !pass;

endmodule

// File: rtl/frame_rx_lane.sv
module frame_rx_lane #(
  parameter int DW        = 32,
  parameter int MAX_BURST = 254,
  parameter int CW        = $clog2(MAX_BURST + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW:0]   word,
  input  logic          step_strobe,
  input  logic          pass,
  input  logic          blocked,
  input  logic          is_async,
  input  logic          sof_en,
  input  logic          sof_align,
  input  logic [DW-1:0] dflt,
  output logic [DW-1:0] o_data,
  output logic          o_valid,
  output logic          o_sof,
  output logic          o_ovf,
  output logic [CW-1:0] cnt_q,
  output logic          take
);

  localparam logic [CW-1:0] LIM = CW'(MAX_BURST);

  function automatic logic has_room(input logic burst, input logic [CW-1:0] n);
    return burst ? (n < LIM) : (n == '0);
  endfunction

  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] n, input logic inc);
    return inc ? n + CW'(1) : n;
  endfunction

  logic [CW-1:0] base;
  logic          first;
  logic          room;
  logic          word_v;
  logic          drop_hit;

  logic          a_valid;
  logic          a_first;
  logic          a_def;
  logic [DW-1:0] a_data;

  assign word_v   = word[DW];
  assign base     = step_strobe ? '0 : cnt_q;
  assign first    = (base == '0);
  assign room     = has_room(is_async, base);
  assign take     = word_v && pass && room;
  assign drop_hit = word_v && pass && is_async && !room;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      a_valid <= 1'b0;
      a_first <= 1'b0;
      a_def   <= 1'b0;
      a_data  <= '0;
      o_data  <= '0;
      o_valid <= 1'b0;
      o_sof   <= 1'b0;
      o_ovf   <= 1'b0;
    end else begin
      cnt_q   <= next_count(base, take);
      a_valid <= take;
      a_first <= first;
      a_def   <= blocked;
      a_data  <= word[DW-1:0];
      o_valid <= a_valid;
      if (a_valid) begin
        o_data <= a_data;
      end else if (a_def) begin
        o_data <= dflt;
      end
      o_sof <= sof_en && (sof_align ? (a_valid && a_first) : (take && first));
      o_ovf <= o_ovf || drop_hit;
    end
  end

endmodule

// File: rtl/frame_rx.sv
module frame_rx #(
  parameter int NPORTS    = 4,
  parameter int DW        = 32,
  parameter int MAX_BURST = 254
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPORTS*33-1:0] port_word,
  input  logic                 step_strobe,
  input  logic [1:0]           app_state,
  input  logic                 protect_en,
  input  logic [NPORTS-1:0]    async_mask,
  input  logic [NPORTS-1:0]    sof_en_mask,
  input  logic                 sof_align,
  input  logic [31:0]          default_data,
  output logic [NPORTS*32-1:0] out_data,
  output logic [NPORTS-1:0]    out_valid,
  output logic [NPORTS-1:0]    out_sof,
  output logic [NPORTS-1:0]    overflow
);

  localparam int CW = $clog2(MAX_BURST + 1);
  localparam int WW = DW + 1;

  logic                 gate_pass;
  logic                 gate_block;
  logic [NPORTS*CW-1:0] lane_cnt;
  logic [NPORTS-1:0]    lane_take;

  frame_rx_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .protect_en (protect_en),
    .app_state  (app_state),
    .pass       (gate_pass),
    .blocked    (gate_block)
  );

  for (genvar i = 0; i < NPORTS; i++) begin : g_lane
    frame_rx_lane #(
      .DW        (DW),
      .MAX_BURST (MAX_BURST),
      .CW        (CW)
    ) u_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .word        (port_word[i*WW +: WW]),
      .step_strobe (step_strobe),
      .pass        (gate_pass),
      .blocked     (gate_block),
      .is_async    (async_mask[i]),
      .sof_en      (sof_en_mask[i]),
      .sof_align   (sof_align),
      .dflt        (default_data),
      .o_data      (out_data[i*DW +: DW]),
      .o_valid     (out_valid[i]),
      .o_sof       (out_sof[i]),
      .o_ovf       (overflow[i]),
      .cnt_q       (lane_cnt[i*CW +: CW]),
      .take        (lane_take[i])
    );
  end

endmodule

// File: rtl/frame_rx_chk.sv
module frame_rx_chk #(
  parameter int NPORTS    = 4,
  parameter int CW        = 8,
  parameter int MAX_BURST = 254
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 protect_en,
  input logic [1:0]           app_state,
  input logic                 sof_align,
  input logic [NPORTS-1:0]    sof_en_mask,
  input logic [NPORTS-1:0]    async_mask,
  input logic [NPORTS-1:0]    out_valid,
  input logic [NPORTS-1:0]    out_sof,
  input logic [NPORTS-1:0]    overflow,
  input logic [NPORTS-1:0]    lane_take,
  input logic [NPORTS*CW-1:0] lane_cnt
);

  localparam logic [CW-1:0] LIM = CW'(MAX_BURST);

  // R10: a Stop cycle under protection yields no valid two clocks later
  a_r10_stop_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (protect_en && app_state == 2'd0) |-> ##2 (out_valid == '0));

  for (genvar i = 0; i < NPORTS; i++) begin : g_chk
    // R5: overrun flag is sticky
    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overflow[i] |=> overflow[i]);

    // R4: per-step count never passes the limit
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      lane_cnt[i*CW +: CW] <= LIM);

    // R6: pulse only on enabled lanes
    a_r6_sof_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof[i] |-> $past(sof_en_mask[i]));

    // R7: aligned pulse coincides with valid
    a_r7_sof_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (out_sof[i] && $past(sof_align)) |-> out_valid[i]);

    // R8: leading pulse is followed by valid
    a_r8_sof_leads: assert property (@(posedge clk) disable iff (!rst_n)
      (out_sof[i] && !$past(sof_align)) |=> out_valid[i]);

    // R1: an accepted word reaches the output two clocks later
    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
      lane_take[i] |-> ##2 out_valid[i]);

    // R5: single-sample lanes never flag an overrun
    a_r5_sync_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!async_mask[i]) && !$past(overflow[i])) |-> !overflow[i]);
  end

endmodule

bind frame_rx frame_rx_chk #(
  .NPORTS    (NPORTS),
  .CW        (CW),
  .MAX_BURST (MAX_BURST)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .protect_en  (protect_en),
  .app_state   (app_state),
  .sof_align   (sof_align),
  .sof_en_mask (sof_en_mask),
  .async_mask  (async_mask),
  .out_valid   (out_valid),
  .out_sof     (out_sof),
  .overflow    (overflow),
  .lane_take   (lane_take),
  .lane_cnt    (lane_cnt)
);

// File: tb/sim_frame_rx.sv
`timescale 1ns/1ps
module sim_frame_rx;

  localparam int NP  = 4;
  localparam int MAXB = 254;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NP*33-1:0] port_word;
  logic            step_strobe = 1'b0;
  logic [1:0]      app_state = 2'd0;
  logic            protect_en = 1'b0;
  logic [NP-1:0]   async_mask = '0;
  logic [NP-1:0]   sof_en_mask = '0;
  logic            sof_align = 1'b0;
  logic [31:0]     default_data = 32'hD5F0_0A11;
  logic [NP*32-1:0] out_data;
  logic [NP-1:0]   out_valid;
  logic [NP-1:0]   out_sof;
  logic [NP-1:0]   overflow;

  logic [32:0] w [NP];

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NP; i++) port_word[i*33 +: 33] = w[i];
  end

  frame_rx u0 (
    .clk(clk), .rst_n(rst_n), .port_word(port_word), .step_strobe(step_strobe),
    .app_state(app_state), .protect_en(protect_en), .async_mask(async_mask),
    .sof_en_mask(sof_en_mask), .sof_align(sof_align), .default_data(default_data),
    .out_data(out_data), .out_valid(out_valid), .out_sof(out_sof), .overflow(overflow)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit model_on = 1'b0;

  // Reference model, written from the requirements
  int          m_n [NP];
  logic [1:0]  m_hist;
  bit          m_av [NP], m_af [NP], m_ad [NP];
  logic [31:0] m_aw [NP];
  bit          m_ov [NP], m_os [NP], m_of [NP];
  logic [31:0] m_od [NP];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hist = 2'd0;
      for (int i = 0; i < NP; i++) begin
        m_n[i] = 0; m_av[i] = 0; m_af[i] = 0; m_ad[i] = 0; m_aw[i] = 0;
        m_ov[i] = 0; m_os[i] = 0; m_of[i] = 0; m_od[i] = 0;
      end
    end else begin
      bit ok;
      ok = !protect_en || app_state == 2'd1 || (app_state == 2'd2 && m_hist == 2'd1);
      for (int i = 0; i < NP; i++) begin
        int start; bit lim_ok; bit acc;
        start  = step_strobe ? 0 : m_n[i];
        lim_ok = async_mask[i] ? (start < MAXB) : (start == 0);
        acc    = w[i][32] && ok && lim_ok;
        if (w[i][32] && ok && async_mask[i] && !lim_ok) m_of[i] = 1;
        m_os[i] = sof_en_mask[i] && (sof_align ? (m_av[i] && m_af[i]) : (acc && start == 0));
        m_ov[i] = m_av[i];
        if (m_av[i]) m_od[i] = m_aw[i];
        else if (m_ad[i]) m_od[i] = default_data;
        m_av[i] = acc; m_af[i] = (start == 0); m_ad[i] = !ok; m_aw[i] = w[i][31:0];
        m_n[i] = start + (acc ? 1 : 0);
      end
      if (app_state != 2'd2) m_hist = app_state;
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      for (int i = 0; i < NP; i++) begin
        n_chk++;
        if (out_valid[i] !== m_ov[i]) begin
          n_bad++;
          $display("FAIL R3 R4 R9 R11 lane %0d valid: got %0b exp %0b t=%0t", i, out_valid[i], m_ov[i], $time);
        end
        n_chk++;
        if (out_data[i*32 +: 32] !== m_od[i]) begin
          n_bad++;
          $display("FAIL R1 R10 lane %0d data: got %h exp %h t=%0t", i, out_data[i*32 +: 32], m_od[i], $time);
        end
        n_chk++;
        if (out_sof[i] !== m_os[i]) begin
          n_bad++;
          $display("FAIL R6 R7 R8 lane %0d sof: got %0b exp %0b t=%0t", i, out_sof[i], m_os[i], $time);
        end
        n_chk++;
        if (overflow[i] !== m_of[i]) begin
          n_bad++;
          $display("FAIL R5 lane %0d overflow: got %0b exp %0b t=%0t", i, overflow[i], m_of[i], $time);
        end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h exp %0h", tag, got, exp);
    end
  endtask

  logic [15:0] lfsr = 16'hACE1;
  function automatic logic [15:0] step_lfsr(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic drive_cycle(input bit strobe, input logic [NP-1:0] vmask);
    @(negedge clk);
    step_strobe = strobe;
    for (int i = 0; i < NP; i++) begin
      lfsr = step_lfsr(lfsr);
      w[i] = {vmask[i], lfsr, lfsr ^ 16'h5A5A};
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive_cycle(1'b0, '0);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NP; i++) w[i] = '0;
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 valid", 32'(out_valid), 0);
    check("R12 sof", 32'(out_sof), 0);
    check("R12 overflow", 32'(overflow), 0);
    check("R12 data", out_data[31:0], 0);
    rst_n = 1'b1;
    model_on = 1'b1;

    // R11 with R2: lanes 0 and 2 in burst mode, protection off
    async_mask  = 4'b0101;
    sof_en_mask = 4'b0111;
    for (int al = 0; al < 2; al++) begin
      sof_align = al[0];
      for (int st = 0; st < 4; st++) begin
        app_state = st[1:0];
        for (int s = 0; s < 10; s++) begin
          for (int c = 0; c < 8; c++) begin
            lfsr = step_lfsr(lfsr);
            drive_cycle(c == 0, lfsr[3:0]);
          end
        end
      end
    end
    idle(3);

    // R9/R10: sweep every pair of run states under protection
    protect_en = 1'b1;
    for (int al = 0; al < 2; al++) begin
      sof_align = al[0];
      for (int a = 0; a < 4; a++) begin
        for (int b = 0; b < 4; b++) begin
          app_state = a[1:0];
          for (int c = 0; c < 5; c++) drive_cycle(c == 0, 4'b1111);
          app_state = b[1:0];
          for (int c = 0; c < 5; c++) drive_cycle(c == 2, 4'b1111);
        end
      end
    end
    // R10: directed default after Stop
    app_state = 2'd0;
    drive_cycle(1'b1, 4'b1111);
    idle(2);
    check("R10 default lane3", out_data[3*32 +: 32], default_data);
    check("R10 valid low", 32'(out_valid), 0);

    // R8: leading pulse on a single-sample lane
    protect_en = 1'b0;
    sof_align = 1'b0;
    drive_cycle(1'b1, 4'b0010);
    drive_cycle(1'b0, 4'b0000);
    check("R8 sof ahead", 32'(out_sof[1]), 1);
    check("R8 valid not yet", 32'(out_valid[1]), 0);
    drive_cycle(1'b0, 4'b0000);
    check("R8 valid follows", 32'(out_valid[1]), 1);
    idle(2);

    // R4/R5: overrun a burst step; R3 single lanes take one word
    begin
      int got0, got1;
      got0 = 0; got1 = 0;
      for (int k = 0; k < MAXB + 2; k++) begin
        drive_cycle(k == 0, 4'b1111);
        got0 += out_valid[0]; got1 += out_valid[1];
      end
      for (int k = 0; k < 3; k++) begin
        drive_cycle(1'b0, 4'b0000);
        got0 += out_valid[0]; got1 += out_valid[1];
      end
      check("R4 burst count lane0", 32'(got0), MAXB);
      check("R3 single count lane1", 32'(got1), 1);
      check("R5 overflow set on burst lanes", 32'(overflow), 32'h5);
    end
    // R4: next strobe restarts the count
    for (int k = 0; k < 6; k++) drive_cycle(k == 0, 4'b0001);
    idle(4);
    check("R5 still sticky", 32'(overflow), 32'h5);

    model_on = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule